// File: doc/BRIEF.md
# Bus test package controller

This controller moves scan test data from one on-chip test source, over a shared bus that carries one transfer at a time, into the buffers that sit in front of several cores. A schedule computed beforehand is held in an external ROM. The controller walks through it one entry at a time. Each entry names a target core, the earliest time at which its transfer may start on the bus, and how many packages are merged into that transfer.

For each entry the controller waits until its internal time counter reaches the entry's send time. It then raises the select line of the target core and enables the source. It holds both until that core acknowledges that the whole transfer has arrived. Only then does it fetch the next entry. Transport stays sequential, while the cores apply what they have buffered in parallel.

A terminating entry ends the run and raises done. A sticky overrun flag reports a run that goes past the allowed test time. A sticky error flag reports an acknowledge from a core that is not selected. A start pulse restarts the whole sequence.

Top module: `tpkt_bus_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released until the first start, sel_o, src_en_o, done_o, overrun_o and error_o are 0, and rom_addr_o and time_o are 0.
- R2: After a start, time_o counts up by one per clock from 0. An entry is launched at the clock edge where the counter value is at least the entry's send time, so its select is first seen together with time_o equal to that value plus one. No select appears earlier.
- R3: At most one bit of sel_o is high at any time, and src_en_o is high exactly when some select bit is high.
- R4: The select of the entry's core (bit index = rom_core_i) stays high until that core's ack_i bit is sampled high. It drops at that edge, and the next entry cannot be launched before the following edge.
- R5: Entries are taken in ROM order. rom_addr_o starts at 0 and grows by one at each accepted acknowledge, and by no other event.
- R6: While a select is high, xfer_cnt_o carries the merged package count of the entry being transferred.
- R7: An entry with rom_last_i = 1 ends the run. done_o rises at the next edge, and from then on it stays high with no select until the next start.
- R8: overrun_o is set at an edge where the run is still active (not done) and time_o is greater than t_max_i. It stays set until the next start.
- R9: An ack_i bit for a core whose select is low sets error_o, which stays set until the next start. Such an acknowledge changes neither the select nor rom_addr_o.
- R10: A start pulse in the middle of a run clears the select, done, overrun and error, sets time_o and rom_addr_o to 0, and begins the schedule again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart the time counter and schedule pointer |
| t_max_i | input | TIME_W | Maximum allowed test time |
| ack_i | input | NUM_CORES | Per-core receive-complete acknowledge |
| rom_core_i | input | CORE_W | Target core of the addressed entry |
| rom_time_i | input | TIME_W | Send time of the addressed entry |
| rom_cnt_i | input | CNT_W | Merged package count of the addressed entry |
| rom_last_i | input | 1 | Addressed entry terminates the schedule |
| rom_addr_o | output | ADDR_W | Schedule ROM address |
| time_o | output | TIME_W | Test time counter |
| sel_o | output | NUM_CORES | Per-core select |
| src_en_o | output | 1 | Test source enable |
| xfer_cnt_o | output | CNT_W | Package count of the active transfer |
| done_o | output | 1 | Schedule finished |
| overrun_o | output | 1 | Test time limit exceeded |
| error_o | output | 1 | Acknowledge from a core that is not selected |

## Verification
The assertions assume that the ROM answers rom_addr_o in the same cycle and names only existing cores. They also assume that start_i is a one-cycle pulse. The stimulus keeps every schedule's core indices below the core count, and it drives start_i, ack_i and t_max_i only on falling edges. Stray acknowledges are injected on purpose, both while another core is selected and while no core is selected. t_max_i is moved both below and above the length of a run, so the error and overrun paths are exercised without breaking those assumptions.

// File: rtl/tpkt_pkg.sv
package tpkt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/tpkt_timer.sv
module tpkt_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              count_i,
  input  logic              run_i,
  input  logic [TIME_W-1:0] t_max_i,
  output logic [TIME_W-1:0] time_o,
  output logic              overrun_o
);
  localparam logic [TIME_W-1:0] TIME_MAX = '1;

  logic [TIME_W-1:0] time_q;
  logic              ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      ovr_q  <= 1'b0;
    end else if (start_i) begin
      time_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (count_i && time_q != TIME_MAX) time_q <= time_q + 1'b1;
      if (run_i && time_q > t_max_i) ovr_q <= 1'b1;
    end
  end

  assign time_o    = time_q;
  assign overrun_o = ovr_q;

  a_r8_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i && time_q > t_max_i) |=> ovr_q);
  a_r8_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !start_i) |=> ovr_q);
  a_r10_start_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (time_q == '0 && !ovr_q));
endmodule

// File: rtl/tpkt_ack_mon.sv
module tpkt_ack_mon #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [NUM_CORES-1:0] ack_i,
  input  logic [NUM_CORES-1:0] sel_i,
  output logic                 ack_hit_o,
  output logic                 error_o
);
  logic stray;
  logic err_q;

  assign ack_hit_o = |(ack_i & sel_i);
  assign stray     = |(ack_i & ~sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (start_i)   err_q <= 1'b0;
    else if (stray)     err_q <= 1'b1;
  end

  assign error_o = err_q;

  a_r9_stray_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack_i & ~sel_i) && !start_i) |=> err_q);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !start_i) |=> err_q);
endmodule

// File: rtl/tpkt_seq.sv
module tpkt_seq
  import tpkt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int TIME_W    = 16,
  parameter int CNT_W     = 4,
  parameter int ADDR_W    = 4,
  parameter int CORE_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [TIME_W-1:0]    time_i,
  input  logic [CORE_W-1:0]    rom_core_i,
  input  logic [TIME_W-1:0]    rom_time_i,
  input  logic [CNT_W-1:0]     rom_cnt_i,
  input  logic                 rom_last_i,
  input  logic                 ack_hit_i,
  output logic [ADDR_W-1:0]    rom_addr_o,
  output logic [NUM_CORES-1:0] sel_o,
  output logic [CNT_W-1:0]     cnt_o,
  output seq_state_e           state_o,
  output logic                 done_o
);
  seq_state_e           state_q;
  logic [ADDR_W-1:0]    ptr_q;
  logic [NUM_CORES-1:0] sel_q;
  logic [NUM_CORES-1:0] core_dec;
  logic [CNT_W-1:0]     cnt_q;
  logic                 done_q;
  logic                 launch;
  logic                 retire;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_dec
    assign core_dec[g] = (rom_core_i == CORE_W'(g));
  end

  assign launch = (state_q == ST_WAIT) && !rom_last_i && (time_i >= rom_time_i);
  assign retire = (state_q == ST_SEND) && ack_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      sel_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_WAIT;
      ptr_q   <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (rom_last_i) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
          end else if (launch) begin
            state_q <= ST_SEND;
            sel_q   <= core_dec;
            cnt_q   <= rom_cnt_i;
          end
        end
        ST_SEND: begin
          if (retire) begin
            state_q <= ST_WAIT;
            sel_q   <= '0;
            ptr_q   <= ptr_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign rom_addr_o = ptr_q;
  assign sel_o      = sel_q;
  assign cnt_o      = cnt_q;
  assign state_o    = state_q;
  assign done_o     = done_q;

  a_r3_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_q));
  a_r2_no_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !start_i && time_i < rom_time_i) |=> sel_q == '0);
  a_r4_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != '0 && !ack_hit_i && !start_i) |=> $stable(sel_q));
  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !(state_q == ST_SEND && ack_hit_i)) |=> $stable(ptr_q));
  a_r4_retire_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND && ack_hit_i && !start_i) |=>
      (sel_q == '0 && ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));
  a_r6_cnt_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != '0 && !ack_hit_i && !start_i) |=> $stable(cnt_q));
  a_r7_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> (done_q && sel_q == '0));
endmodule

// File: rtl/tpkt_bus_ctrl.sv
module tpkt_bus_ctrl
  import tpkt_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int TIME_W      = 16,
  parameter int CNT_W       = 4,
  parameter int SCHED_DEPTH = 16,
  localparam int ADDR_W     = (SCHED_DEPTH > 1) ? $clog2(SCHED_DEPTH) : 1,
  localparam int CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [TIME_W-1:0]    t_max_i,
  input  logic [NUM_CORES-1:0] ack_i,
  input  logic [CORE_W-1:0]    rom_core_i,
  input  logic [TIME_W-1:0]    rom_time_i,
  input  logic [CNT_W-1:0]     rom_cnt_i,
  input  logic                 rom_last_i,
  output logic [ADDR_W-1:0]    rom_addr_o,
  output logic [TIME_W-1:0]    time_o,
  output logic [NUM_CORES-1:0] sel_o,
  output logic                 src_en_o,
  output logic [CNT_W-1:0]     xfer_cnt_o,
  output logic                 done_o,
  output logic                 overrun_o,
  output logic                 error_o
);
  seq_state_e           state;
  logic [NUM_CORES-1:0] sel;
  logic [TIME_W-1:0]    time_now;
  logic                 ack_hit;
  logic                 counting;
  logic                 running;

  assign counting = (state != ST_IDLE);
  assign running  = (state == ST_WAIT) || (state == ST_SEND);

  tpkt_timer #(.TIME_W(TIME_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .count_i  (counting),
    .run_i    (running),
    .t_max_i  (t_max_i),
    .time_o   (time_now),
    .overrun_o(overrun_o)
  );

  tpkt_ack_mon #(.NUM_CORES(NUM_CORES)) u_ack_mon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ack_i    (ack_i),
    .sel_i    (sel),
    .ack_hit_o(ack_hit),
    .error_o  (error_o)
  );

  tpkt_seq #(
    .NUM_CORES(NUM_CORES),
    .TIME_W   (TIME_W),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .CORE_W   (CORE_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .time_i    (time_now),
    .rom_core_i(rom_core_i),
    .rom_time_i(rom_time_i),
    .rom_cnt_i (rom_cnt_i),
    .rom_last_i(rom_last_i),
    .ack_hit_i (ack_hit),
    .rom_addr_o(rom_addr_o),
    .sel_o     (sel),
    .cnt_o     (xfer_cnt_o),
    .state_o   (state),
    .done_o    (done_o)
  );

  assign sel_o    = sel;
  assign src_en_o = |sel;
  assign time_o   = time_now;
endmodule

// File: tb/tpkt_bus_ctrl_bench.sv
module tpkt_bus_ctrl_bench;
  localparam int NC = 4;
  localparam int DEPTH = 16;
  localparam int TMAXC = 65535;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] t_max_i = 16'd1000;
  logic [3:0]  ack_i;
  logic [3:0]  ack_auto = '0;
  logic [3:0]  stray = '0;
  logic [1:0]  rom_core_i;
  logic [15:0] rom_time_i;
  logic [3:0]  rom_cnt_i;
  logic        rom_last_i;
  logic [3:0]  rom_addr_o;
  logic [15:0] time_o;
  logic [3:0]  sel_o;
  logic        src_en_o;
  logic [3:0]  xfer_cnt_o;
  logic        done_o, overrun_o, error_o;

  int s_core [DEPTH];
  int s_time [DEPTH];
  int s_cnt  [DEPTH];
  bit s_last [DEPTH];
  int lat    [NC] = '{3, 5, 1, 2};
  int wcnt   [NC] = '{0, 0, 0, 0};

  int checks = 0;
  int fails = 0;
  bit cmp_en = 0;

  always #4 clk_i = ~clk_i;

  assign ack_i      = ack_auto | stray;
  assign rom_core_i = 2'(s_core[rom_addr_o]);
  assign rom_time_i = 16'(s_time[rom_addr_o]);
  assign rom_cnt_i  = 4'(s_cnt[rom_addr_o]);
  assign rom_last_i = s_last[rom_addr_o];

  tpkt_bus_ctrl u_tpkt_bus_ctrl (
    .clk_i, .rst_ni, .start_i, .t_max_i, .ack_i,
    .rom_core_i, .rom_time_i, .rom_cnt_i, .rom_last_i,
    .rom_addr_o, .time_o, .sel_o, .src_en_o, .xfer_cnt_o,
    .done_o, .overrun_o, .error_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: phases 0 idle, 1 waiting, 2 sending, 3 finished
  int m_state = 0, m_time = 0, m_ptr = 0, m_sel = -1, m_cnt = 0;
  bit m_done = 0, m_ovr = 0, m_err = 0;
  int o_st, o_tm;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_time = 0; m_ptr = 0; m_sel = -1; m_cnt = 0;
      m_done = 0; m_ovr = 0; m_err = 0;
    end else if (start_i) begin
      m_state = 1; m_time = 0; m_ptr = 0; m_sel = -1;
      m_done = 0; m_ovr = 0; m_err = 0;
    end else begin
      o_st = m_state;
      o_tm = m_time;
      for (int c = 0; c < NC; c++)
        if (ack_i[c] && c != m_sel) m_err = 1;
      if ((o_st == 1 || o_st == 2) && o_tm > int'(t_max_i)) m_ovr = 1;
      if (o_st == 1) begin
        if (s_last[m_ptr]) begin
          m_state = 3; m_done = 1;
        end else if (o_tm >= s_time[m_ptr]) begin
          m_sel = s_core[m_ptr]; m_cnt = s_cnt[m_ptr]; m_state = 2;
        end
      end else if (o_st == 2) begin
        if (ack_i[m_sel]) begin
          m_sel = -1; m_ptr = (m_ptr + 1) % DEPTH; m_state = 1;
        end
      end
      if (o_st != 0 && o_tm < TMAXC) m_time = o_tm + 1;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (cmp_en) begin
      chk("R4", "sel_o", int'(sel_o), (m_sel >= 0) ? (1 << m_sel) : 0);
      chk("R3", "src_en_o", int'(src_en_o), int'(m_sel >= 0));
      chk("R5", "rom_addr_o", int'(rom_addr_o), m_ptr);
      chk("R2", "time_o", int'(time_o), m_time);
      if (m_sel >= 0) chk("R6", "xfer_cnt_o", int'(xfer_cnt_o), m_cnt);
      chk("R7", "done_o", int'(done_o), int'(m_done));
      chk("R8", "overrun_o", int'(overrun_o), int'(m_ovr));
      chk("R9", "error_o", int'(error_o), int'(m_err));
    end
  end

  // core-side acknowledge emulation
  always @(negedge clk_i) begin
    for (int c = 0; c < NC; c++) begin
      ack_auto[c] = 1'b0;
      if (sel_o[c]) begin
        wcnt[c]++;
        if (wcnt[c] >= lat[c]) begin
          ack_auto[c] = 1'b1;
          wcnt[c] = 0;
        end
      end else begin
        wcnt[c] = 0;
      end
    end
  end

  task automatic put(input int i, input int core, input int t, input int n, input bit last);
    s_core[i] = core; s_time[i] = t; s_cnt[i] = n; s_last[i] = last;
  endtask

  task automatic load_a();
    for (int i = 0; i < DEPTH; i++) put(i, 0, 0, 0, 1'b1);
    put(0, 0, 5, 1, 1'b0);
    put(1, 1, 8, 2, 1'b0);
    put(2, 2, 40, 1, 1'b0);
    put(3, 1, 10, 3, 1'b0);
    put(4, 3, 12, 7, 1'b0);
    put(5, 0, 0, 0, 1'b1);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    int n = 0;
    while (!done_o && n < limit) begin
      @(negedge clk_i);
      n++;
    end
    chk("R7", "done reached", int'(done_o), 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int guard;
    load_a();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "sel_o", int'(sel_o), 0);
    chk("R1", "src_en_o", int'(src_en_o), 0);
    chk("R1", "done_o", int'(done_o), 0);
    chk("R1", "flags", int'({overrun_o, error_o}), 0);
    chk("R1", "rom_addr_o", int'(rom_addr_o), 0);
    chk("R1", "time_o", int'(time_o), 0);
    rst_ni = 1'b1;
    cmp_en = 1;
    repeat (4) @(negedge clk_i);
    chk("R1", "idle time_o", int'(time_o), 0);

    // plain schedule, first launch timing
    pulse_start();
    guard = 0;
    while (sel_o == '0 && guard < 200) begin @(negedge clk_i); guard++; end
    chk("R2", "time at first select", int'(time_o), 6);
    chk("R4", "first target core 0", int'(sel_o), 1);
    wait_done(2000);
    chk("R9", "no error", int'(error_o), 0);
    repeat (5) @(negedge clk_i);
    chk("R7", "no select after done", int'(sel_o), 0);

    // stray acknowledges during a transfer and while waiting
    pulse_start();
    guard = 0;
    while (!sel_o[1] && guard < 200) begin @(negedge clk_i); guard++; end
    stray = 4'b1000;
    @(negedge clk_i);
    stray = 4'b0000;
    chk("R9", "error after stray ack", int'(error_o), 1);
    chk("R9", "select kept", int'(sel_o), 2);
    guard = 0;
    while (sel_o != '0 && guard < 200) begin @(negedge clk_i); guard++; end
    stray = 4'b0001;
    @(negedge clk_i);
    stray = 4'b0000;
    chk("R9", "no launch on stray", int'(sel_o), 0);
    wait_done(2000);
    chk("R9", "error sticky", int'(error_o), 1);

    // restart mid-run with overrun and error pending
    t_max_i = 16'd3;
    pulse_start();
    repeat (10) @(negedge clk_i);
    stray = 4'b0100;
    @(negedge clk_i);
    stray = 4'b0000;
    chk("R8", "overrun before restart", int'(overrun_o), 1);
    pulse_start();
    t_max_i = 16'd1000;
    chk("R10", "time_o", int'(time_o), 0);
    chk("R10", "rom_addr_o", int'(rom_addr_o), 0);
    chk("R10", "sel_o", int'(sel_o), 0);
    chk("R10", "error_o", int'(error_o), 0);
    chk("R10", "overrun_o", int'(overrun_o), 0);
    wait_done(2000);
    chk("R8", "no overrun with loose limit", int'(overrun_o), 0);

    // overrun with a tight limit
    t_max_i = 16'd15;
    pulse_start();
    wait_done(2000);
    chk("R8", "overrun set", int'(overrun_o), 1);
    repeat (3) @(negedge clk_i);
    chk("R8", "overrun sticky", int'(overrun_o), 1);
    t_max_i = 16'd1000;

    // terminating entry first
    put(0, 2, 0, 5, 1'b1);
    pulse_start();
    repeat (5) @(negedge clk_i);
    chk("R7", "empty schedule done", int'(done_o), 1);
    chk("R7", "empty schedule no select", int'(sel_o), 0);

    // merged counts and same-time entries
    load_a();
    put(0, 3, 0, 15, 1'b0);
    put(1, 3, 0, 9, 1'b0);
    pulse_start();
    wait_done(2000);

    cmp_en = 0;
    summary();
    $finish;
  end
endmodule